// File: doc/BRIEF.md
# Core Idle Power State Controller

This block steps a single processor core into and out of two idle depths. A request naming the depth is taken only while the core is running. The shallow depth (nap) stops the execution-unit clocks and asks for a lower core frequency. Caches and translation buffers stay powered and coherent, so a wake event brings the core back on the next clock edge.

The deep depth (sleep) asks for a cache and translation-buffer purge first, with every clock still running. Only after the purge is acknowledged does it stop the clocks to the whole core and its caches and select the retention voltage. A wake event from sleep selects nominal voltage and waits for the rail to report ready for a qualified interval. Only then do the clocks restart. There is no re-initialization step.

A wake event that arrives while the purge is still running is remembered. When the purge completes, the controller goes straight to the ramp state and never selects retention voltage. The rail hardware, the purge engine and software state save are outside the block; they appear here only as handshake inputs.

States, encoded on `state_o`: RUN = 0, NAP = 1, SLEEP_PURGE = 2, SLEEP = 3, WAKE_RAMP = 4.

Transitions:
- RUN→NAP: on `idle_req` with `idle_deep` = 0.
- RUN→SLEEP_PURGE: on `idle_req` with `idle_deep` = 1.
- NAP→RUN: on `wake_evt`.
- SLEEP_PURGE→SLEEP: on `purge_done` with no wake seen.
- SLEEP_PURGE→WAKE_RAMP: on `purge_done` with a wake held or present.
- SLEEP→WAKE_RAMP: on `wake_evt`.
- WAKE_RAMP→RUN: on qualified `volt_ready`.

Top module: `core_idle_ctrl`

## Requirements
- R1: After reset the state is RUN (0). `eu_clk_en` and `core_clk_en` are 1, and `freq_low`, `purge_req`, `volt_retention` and `wake_done` are 0.
- R2: `idle_req` is acted on only in RUN. In RUN, `idle_deep` = 0 moves to NAP (1) and `idle_deep` = 1 moves to SLEEP_PURGE (2) at the next edge. In every other state `idle_req` has no effect.
- R3: In NAP, `eu_clk_en` = 0, `core_clk_en` = 1, `freq_low` = 1, `purge_req` = 0 and `volt_retention` = 0.
- R4: In NAP, `wake_evt` returns the state to RUN at the next edge. `eu_clk_en` returns to 1 and `freq_low` to 0 in that same cycle.
- R5: In SLEEP_PURGE, `purge_req` = 1 and both clock enables stay 1. The state holds until `purge_done` is sampled high.
- R6: `purge_done` in SLEEP_PURGE, with no wake seen since entry, moves to SLEEP (3). SLEEP has both clock enables 0, `volt_retention` = 1, `freq_low` = 1 and `purge_req` = 0.
- R7: `wake_evt` in SLEEP moves to WAKE_RAMP (4). WAKE_RAMP has `volt_retention` = 0, both clock enables 0 and `freq_low` = 1.
- R8: WAKE_RAMP moves to RUN only at an edge where `volt_ready` is high and was also high at the READY_CYCLES (default 1) edges just before it while in WAKE_RAMP. A low sample restarts the count.
- R9: A `wake_evt` seen in any cycle of SLEEP_PURGE, including the cycle of `purge_done`, makes `purge_done` lead to WAKE_RAMP. `volt_retention` then stays 0 throughout.
- R10: `wake_done` is 1 for exactly the first RUN cycle after NAP or WAKE_RAMP, and 0 at all other times.
- R11: `wake_evt` in RUN has no effect: the state stays RUN and `wake_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to enter an idle depth |
| idle_deep | input | 1 | Depth select: 0 nap, 1 sleep |
| wake_evt | input | 1 | Wake event |
| purge_done | input | 1 | Purge engine acknowledge |
| volt_ready | input | 1 | Rail reports nominal voltage reached |
| eu_clk_en | output | 1 | Execution-unit clock enable |
| core_clk_en | output | 1 | Whole core and cache clock enable |
| freq_low | output | 1 | Request for reduced core frequency |
| purge_req | output | 1 | Cache and translation-buffer purge request |
| volt_retention | output | 1 | Voltage select: 1 retention, 0 nominal |
| wake_done | output | 1 | One-cycle wake-complete pulse |
| state_o | output | 3 | Current state code |

## Verification
The wake event and the purge acknowledge can land in the same SLEEP_PURGE cycle. The wake event can also arrive earlier in the purge and be held. The bench drives both cases: one pulses `wake_evt` two cycles before `purge_done`, and the other raises the two inputs together. In each case it expects WAKE_RAMP with `volt_retention` never set. A behavioural model, stepped on every edge, judges each output in every cycle. Qualification of `volt_ready` is also exercised with a dropout in the middle of the ramp.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_NAP   = 3'd1,
        ST_PURGE = 3'd2,
        ST_SLEEP = 3'd3,
        ST_RAMP  = 3'd4
    } idle_state_e;

    typedef struct packed {
        logic eu_clk_en;
        logic core_clk_en;
        logic freq_low;
        logic purge_req;
        logic volt_retention;
    } idle_ctl_t;

endpackage

// File: rtl/volt_ready_qual.sv
module volt_ready_qual #(
    parameter int READY_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic volt_ready,
    output logic ready_ok
);
    localparam int CW = $clog2(READY_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(READY_CYCLES);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!active || !volt_ready) begin
            hi_cnt <= '0;
        end else if (hi_cnt != CNT_MAX) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    always_comb begin
        ready_ok = active && volt_ready && (hi_cnt == CNT_MAX);
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= CNT_MAX);
endmodule

// File: rtl/wake_hold.sv
module wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic in_purge,
    input  logic wake_evt,
    output logic wake_seen
);
    logic held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (!in_purge) begin
            held <= 1'b0;
        end else if (wake_evt) begin
            held <= 1'b1;
        end
    end

    always_comb begin
        wake_seen = in_purge && (held || wake_evt);
    end

    // R9
    held_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_purge && wake_evt) |=> (held || !in_purge));
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import core_idle_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idle_req,
    input  logic        idle_deep,
    input  logic        wake_evt,
    input  logic        purge_done,
    input  logic        wake_seen,
    input  logic        ready_ok,
    output idle_state_e state,
    output logic        wake_done
);
    idle_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (idle_req) nxt = idle_deep ? ST_PURGE : ST_NAP;
            ST_NAP:   if (wake_evt) nxt = ST_RUN;
            ST_PURGE: if (purge_done) nxt = wake_seen ? ST_RAMP : ST_SLEEP;
            ST_SLEEP: if (wake_evt) nxt = ST_RAMP;
            ST_RAMP:  if (ready_ok) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            wake_done <= 1'b0;
        end else begin
            state     <= nxt;
            wake_done <= (state != ST_RUN) && (nxt == ST_RUN);
        end
    end

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !idle_req) |=> state == ST_RUN);
    // R5
    purge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PURGE && !purge_done) |=> state == ST_PURGE);
    // R10
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);
endmodule

// File: rtl/idle_out_decode.sv
module idle_out_decode
    import core_idle_pkg::*;
(
    input  idle_state_e state,
    output idle_ctl_t   ctl
);
    always_comb begin
        ctl = '{eu_clk_en: 1'b1, core_clk_en: 1'b1, freq_low: 1'b0,
                purge_req: 1'b0, volt_retention: 1'b0};
        unique case (state)
            ST_RUN: ;
            ST_NAP: begin
                ctl.eu_clk_en = 1'b0;
                ctl.freq_low  = 1'b1;
            end
            ST_PURGE: ctl.purge_req = 1'b1;
            ST_SLEEP: begin
                ctl.eu_clk_en      = 1'b0;
                ctl.core_clk_en    = 1'b0;
                ctl.freq_low       = 1'b1;
                ctl.volt_retention = 1'b1;
            end
            ST_RAMP: begin
                ctl.eu_clk_en   = 1'b0;
                ctl.core_clk_en = 1'b0;
                ctl.freq_low    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
    import core_idle_pkg::*;
#(
    parameter int READY_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic       idle_deep,
    input  logic       wake_evt,
    input  logic       purge_done,
    input  logic       volt_ready,
    output logic       eu_clk_en,
    output logic       core_clk_en,
    output logic       freq_low,
    output logic       purge_req,
    output logic       volt_retention,
    output logic       wake_done,
    output logic [2:0] state_o
);
    idle_state_e state;
    idle_ctl_t   ctl;
    logic        wake_seen;
    logic        ready_ok;

    wake_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_purge  (state == ST_PURGE),
        .wake_evt  (wake_evt),
        .wake_seen (wake_seen)
    );

    volt_ready_qual #(.READY_CYCLES(READY_CYCLES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state == ST_RAMP),
        .volt_ready (volt_ready),
        .ready_ok   (ready_ok)
    );

    idle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .idle_deep  (idle_deep),
        .wake_evt   (wake_evt),
        .purge_done (purge_done),
        .wake_seen  (wake_seen),
        .ready_ok   (ready_ok),
        .state      (state),
        .wake_done  (wake_done)
    );

    idle_out_decode u_dec (
        .state (state),
        .ctl   (ctl)
    );

    always_comb begin
        eu_clk_en      = ctl.eu_clk_en;
        core_clk_en    = ctl.core_clk_en;
        freq_low       = ctl.freq_low;
        purge_req      = ctl.purge_req;
        volt_retention = ctl.volt_retention;
        state_o        = state;
    end

    // R8
    ungate_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(volt_ready));
    // R5
    purge_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge_req |-> (core_clk_en && eu_clk_en));
    // R6
    ret_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(volt_retention) |-> $past(purge_req) && !core_clk_en);
    // R9
    skip_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_req && wake_evt) |=> !volt_retention);
endmodule

// File: tb/core_idle_ctrl_bench.sv
`timescale 1ns/100ps
module core_idle_ctrl_bench;
    localparam int RDY = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, idle_deep = 0, wake_evt = 0, purge_done = 0, volt_ready = 1;
    logic eu_clk_en, core_clk_en, freq_low, purge_req, volt_retention, wake_done;
    logic [2:0] state_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int m_st = 0;
    bit m_pend = 0;
    int m_hi = 0;
    bit m_wd = 0;

    always #2.5 clk = ~clk;

    core_idle_ctrl #(.READY_CYCLES(RDY)) u_core_idle_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_deep(idle_deep),
        .wake_evt(wake_evt), .purge_done(purge_done), .volt_ready(volt_ready),
        .eu_clk_en(eu_clk_en), .core_clk_en(core_clk_en), .freq_low(freq_low),
        .purge_req(purge_req), .volt_retention(volt_retention),
        .wake_done(wake_done), .state_o(state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int nx;
        bit nwd;
        nx = m_st;
        nwd = 0;
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_hi = 0; m_wd = 0;
        end else begin
            case (m_st)
                0: if (idle_req) nx = idle_deep ? 2 : 1;
                1: if (wake_evt) nx = 0;
                2: if (purge_done) nx = (m_pend || wake_evt) ? 4 : 3;
                3: if (wake_evt) nx = 4;
                4: if (volt_ready && m_hi >= RDY) nx = 0;
                default: nx = 0;
            endcase
            if (m_st == 2 && wake_evt) m_pend = 1;
            if (nx != 2) m_pend = 0;
            if (m_st == 4 && volt_ready && nx == 4) m_hi++;
            else m_hi = 0;
            nwd = (m_st != 0) && (nx == 0);
            m_st = nx;
            m_wd = nwd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 state", state_o, m_st);
            chk("R3 eu_clk_en", eu_clk_en, (m_st == 0 || m_st == 2));
            chk("R6 core_clk_en", core_clk_en, (m_st <= 2));
            chk("R7 freq_low", freq_low, (m_st == 1 || m_st >= 3));
            chk("R5 purge_req", purge_req, (m_st == 2));
            chk("R6 volt_retention", volt_retention, (m_st == 3));
            chk("R10 wake_done", wake_done, m_wd);
        end
    end

    task automatic step(input logic ir, input logic dp, input logic we,
                        input logic pd, input logic vr);
        @(negedge clk);
        #0.5;
        idle_req = ir; idle_deep = dp; wake_evt = we; purge_done = pd; volt_ready = vr;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 clocks", {eu_clk_en, core_clk_en}, 3);
        chk("R1 others", {freq_low, purge_req, volt_retention, wake_done}, 0);

        // R11 wake in RUN ignored
        step(0, 0, 1, 0, 1);
        chk("R11 state", state_o, 0);
        step(0, 0, 0, 0, 1);
        chk("R11 wake_done", wake_done, 0);

        // nap entry, R3
        step(1, 0, 0, 0, 1);
        chk("R3 state", state_o, 1);
        chk("R3 eu_clk_en", eu_clk_en, 0);
        // R2 idle_req ignored in NAP
        step(1, 1, 0, 0, 1);
        chk("R2 ignored", state_o, 1);
        step(0, 0, 0, 0, 1);
        // R4 wake from nap
        step(0, 0, 1, 0, 1);
        chk("R4 state", state_o, 0);
        chk("R4 eu/freq", {eu_clk_en, freq_low}, 2);
        chk("R10 pulse", wake_done, 1);
        step(0, 0, 0, 0, 1);
        chk("R10 end", wake_done, 0);

        // deep sleep, R5..R8
        step(1, 1, 0, 0, 1);
        chk("R5 state", state_o, 2);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk("R5 held", purge_req, 1);
        step(0, 0, 0, 1, 1);
        chk("R6 state", state_o, 3);
        chk("R6 retention", volt_retention, 1);
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R7 state", state_o, 4);
        chk("R7 nominal", volt_retention, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk("R8 dropout", state_o, 4);
        step(0, 0, 0, 0, 1);
        chk("R8 first high", state_o, 4);
        step(0, 0, 0, 0, 1);
        chk("R8 exit", state_o, 0);
        chk("R10 sleep wake", wake_done, 1);

        // R9 wake held before purge_done
        step(1, 1, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        chk("R9 held", state_o, 4);
        chk("R9 no ret", volt_retention, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk("R9 back", state_o, 0);

        // R9 wake and purge_done in the same cycle
        step(1, 1, 0, 0, 1);
        step(0, 0, 1, 1, 1);
        chk("R9 same cycle", state_o, 4);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk("R9 same back", state_o, 0);
        step(0, 0, 0, 0, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule